// File: doc/BRIEF.md
# SMBus Indexed Block-Access Register Target

This block is a serial-bus target that lets a host read and write a small bank of byte-wide configuration registers. It uses block transfers that carry a starting register index and a byte count. SCL and SDA are oversampled with the system clock. The block detects start, repeated-start and stop conditions, compares the incoming 7-bit address with one built from a strap input, and pulls the open-drain SDA line low to acknowledge or to send data.

In a write, the host sends the address, a starting index, a byte count and then that many data bytes. Each data byte appears on a one-cycle write strobe at the current index, and the index then advances. In a read, the host first sets the index with a short write. It then issues a repeated start and the read address. The target answers with a count byte taken from a dedicated count register, followed by consecutive registers, for as long as the host keeps acknowledging. The register storage lives outside the block and is reached through an index, a write strobe, write data and a combinational read-data input.

Top module: `smb_blkreg_target`

## Requirements
- R1: The target acknowledges a byte whose upper seven bits equal {BASE_ADDR[6:2], strap} (default BASE_ADDR 7'h68), where strap is the 2-bit value captured on the first clock after reset. Later changes of the strap input do not change the address.
- R2: A write runs as address (bit 0 = 0), index N, count X, then data. The target acknowledges every byte, and data byte k is presented as a one-cycle reg_we pulse with reg_idx = N+k and reg_wdata equal to the byte, sent MSB first.
- R3: Data bytes aimed at an index at or above NUM_REGS (default 12) are acknowledged but produce no reg_we pulse.
- R4: A data byte received after X data bytes have already been accepted is not acknowledged, is not written, and the target ignores the bus until stop.
- R5: After address-write, index N and a repeated start, the read address (bit 0 = 1) is acknowledged. The first byte returned is the register at COUNT_IDX (default 8), followed by registers N, N+1 and so on, MSB first.
- R6: The target keeps sending while the host acknowledges. After a not-acknowledge it leaves SDA released (the host reads 8'hFF) until stop.
- R7: An address that does not match is not acknowledged, and no later byte before the stop is acknowledged or written.
- R8: A read address that follows a plain start rather than a repeated start after an index is not acknowledged.
- R9: A stop or start seen in the middle of a byte abandons the transfer. The next start is then treated as a fresh address phase.
- R10: sda_oe changes only while the synchronised SCL is low.
- R11: reg_we never stays high for two consecutive cycles, and after a stop condition the next cycle shows SDA released and no write.
- R12: Out of reset, sda_oe and reg_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap | input | STRAP_W | Address select value, captured once after reset |
| scl_i | input | 1 | Serial clock line as seen on the pin |
| sda_i | input | 1 | Serial data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_idx | output | 8 | Register index for a write or read |
| reg_wdata | output | 8 | Write data, valid while reg_we is high |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Combinational read data for reg_idx |

## Verification
On every cycle the assertions check that SDA drive only changes while SCL is low and that the write strobe is a single-cycle pulse. They also check that the strobe never targets an index outside the implemented bank, and that a stop leaves the line released. The bench's scenarios are the only way to show that bytes land at the right index and that the count byte comes first in a read. The same holds for refusing an extra data byte, a foreign address or a read after a plain start, and for recovering after a start or stop in the middle of a byte.

// File: rtl/smb_blkreg_pkg.sv
package smb_blkreg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACKW,
        ST_TX,
        ST_ACKR,
        ST_IGNORE
    } st_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_INDEX,
        PH_COUNT,
        PH_DATA
    } ph_e;

    typedef struct packed {
        st_e        st;
        ph_e        ph;
        logic [7:0] sh;
        logic [3:0] bits;
        logic [7:0] idx;
        logic [7:0] remain;
        logic       rs_ok;
        logic       cnt_pend;
        logic       rd_next;
        logic       inc_pend;
        logic       host_ack;
        logic       oe;
        logic       we;
        logic [7:0] wdata;
    } fsm_t;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/smb_cond_detect.sv
module smb_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] prev_d, prev_q;   // {scl, sda} one cycle back

    always_comb begin
        prev_d = {scl_s, sda_s};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 2'b11;
        else        prev_q <= prev_d;
    end

    assign scl_rise  = scl_s & ~prev_q[1];
    assign scl_fall  = ~scl_s & prev_q[1];
    assign start_det = scl_s & prev_q[1] & prev_q[0] & ~sda_s;
    assign stop_det  = scl_s & prev_q[1] & ~prev_q[0] & sda_s;
endmodule

// File: rtl/smb_strap_latch.sv
module smb_strap_latch #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] strap,
    output logic [W-1:0] strap_q
);
    logic [W-1:0] val_d, val_q;
    logic         vld_d, vld_q;

    always_comb begin
        val_d = val_q;
        vld_d = 1'b1;
        if (!vld_q) val_d = strap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
            vld_q <= 1'b0;
        end else begin
            val_q <= val_d;
            vld_q <= vld_d;
        end
    end

    assign strap_q = val_q;
endmodule

// File: rtl/smb_blkreg_fsm.sv
module smb_blkreg_fsm
    import smb_blkreg_pkg::*;
#(
    parameter int NUM_REGS  = 12,
    parameter int COUNT_IDX = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic       sda_s,
    input  logic [6:0] own_addr,
    input  logic [7:0] reg_rdata,
    output logic       sda_oe,
    output logic       reg_we,
    output logic [7:0] reg_wdata,
    output logic [7:0] reg_idx
);
    localparam logic [7:0] LIMIT   = 8'(NUM_REGS);
    localparam logic [7:0] CNT_IDX = 8'(COUNT_IDX);

    fsm_t q, n;
    logic ack;
    logic idx_ok;

    assign idx_ok = q.idx < LIMIT;

    always_comb begin
        n   = q;
        ack = 1'b0;
        n.we = 1'b0;
        if (stop_det) begin
            n.st       = ST_IDLE;
            n.oe       = 1'b0;
            n.cnt_pend = 1'b0;
            n.rd_next  = 1'b0;
            n.inc_pend = 1'b0;
            n.rs_ok    = 1'b0;
        end else if (start_det && q.st != ST_IGNORE) begin
            // repeated start right after the index byte enables a read
            n.rs_ok    = (q.st == ST_RX) && (q.ph == PH_COUNT) && (q.bits <= 4'd1);
            n.st       = ST_RX;
            n.ph       = PH_ADDR;
            n.bits     = 4'd0;
            n.oe       = 1'b0;
            n.cnt_pend = 1'b0;
            n.rd_next  = 1'b0;
            n.inc_pend = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        n.sh   = {q.sh[6:0], sda_s};
                        n.bits = q.bits + 4'd1;
                    end else if (scl_fall && q.bits == 4'd8) begin
                        n.bits  = 4'd0;
                        n.rs_ok = 1'b0;
                        case (q.ph)
                            PH_ADDR: begin
                                if (q.sh[7:1] == own_addr && (!q.sh[0] || q.rs_ok)) begin
                                    ack  = 1'b1;
                                    n.ph = PH_INDEX;
                                    if (q.sh[0]) begin
                                        n.cnt_pend = 1'b1;
                                        n.rd_next  = 1'b1;
                                    end
                                end
                            end
                            PH_INDEX: begin
                                ack   = 1'b1;
                                n.idx = q.sh;
                                n.ph  = PH_COUNT;
                            end
                            PH_COUNT: begin
                                ack      = 1'b1;
                                n.remain = q.sh;
                                n.ph     = PH_DATA;
                            end
                            default: begin
                                if (q.remain != 8'd0) begin
                                    ack        = 1'b1;
                                    n.remain   = q.remain - 8'd1;
                                    n.inc_pend = 1'b1;
                                    n.we       = idx_ok;
                                    n.wdata    = q.sh;
                                end
                            end
                        endcase
                        if (ack) begin
                            n.st = ST_ACKW;
                            n.oe = 1'b1;
                        end else begin
                            n.st = ST_IGNORE;
                            n.oe = 1'b0;
                        end
                    end
                end
                ST_ACKW: begin
                    if (scl_fall) begin
                        if (q.rd_next) begin
                            n.rd_next  = 1'b0;
                            n.sh       = reg_rdata;
                            n.bits     = 4'd0;
                            n.st       = ST_TX;
                            n.oe       = ~reg_rdata[7];
                            n.cnt_pend = 1'b0;
                            if (!q.cnt_pend) n.idx = q.idx + 8'd1;
                        end else begin
                            n.st       = ST_RX;
                            n.oe       = 1'b0;
                            n.inc_pend = 1'b0;
                            if (q.inc_pend) n.idx = q.idx + 8'd1;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.bits == 4'd7) begin
                            n.st       = ST_ACKR;
                            n.oe       = 1'b0;
                            n.host_ack = 1'b0;
                        end else begin
                            n.sh   = {q.sh[6:0], 1'b0};
                            n.bits = q.bits + 4'd1;
                            n.oe   = ~q.sh[6];
                        end
                    end
                end
                ST_ACKR: begin
                    if (scl_rise) begin
                        n.host_ack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.host_ack) begin
                            n.sh   = reg_rdata;
                            n.bits = 4'd0;
                            n.st   = ST_TX;
                            n.oe   = ~reg_rdata[7];
                            n.idx  = q.idx + 8'd1;
                        end else begin
                            n.st = ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign sda_oe    = q.oe;
    assign reg_we    = q.we;
    assign reg_wdata = q.wdata;
    assign reg_idx   = q.cnt_pend ? CNT_IDX : q.idx;
endmodule

// File: rtl/smb_blkreg_target.sv
module smb_blkreg_target #(
    parameter logic [6:0] BASE_ADDR   = 7'h68,
    parameter int         STRAP_W     = 2,
    parameter int         SYNC_STAGES = 2,
    parameter int         NUM_REGS    = 12,
    parameter int         COUNT_IDX   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    output logic [7:0]         reg_idx,
    output logic [7:0]         reg_wdata,
    output logic               reg_we,
    input  logic [7:0]         reg_rdata
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw_lines, sync_lines;
    logic             scl_s, sda_s;
    logic             scl_rise, scl_fall, start_det, stop_det;
    logic [STRAP_W-1:0] strap_q;
    logic [6:0]       own_addr;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_sync
        smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_lines[g]),
            .dout (sync_lines[g])
        );
    end

    assign scl_s = sync_lines[1];
    assign sda_s = sync_lines[0];

    smb_cond_detect u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    smb_strap_latch #(.W(STRAP_W)) u_strap (
        .clk    (clk),
        .rst_n  (rst_n),
        .strap  (strap),
        .strap_q(strap_q)
    );

    assign own_addr = {BASE_ADDR[6:STRAP_W], strap_q};

    smb_blkreg_fsm #(.NUM_REGS(NUM_REGS), .COUNT_IDX(COUNT_IDX)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .sda_s    (sda_s),
        .own_addr (own_addr),
        .reg_rdata(reg_rdata),
        .sda_oe   (sda_oe),
        .reg_we   (reg_we),
        .reg_wdata(reg_wdata),
        .reg_idx  (reg_idx)
    );
endmodule

// File: rtl/smb_blkreg_chk.sv
module smb_blkreg_chk #(
    parameter int NUM_REGS = 12
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       stop_det,
    input logic       sda_oe,
    input logic       reg_we,
    input logic [7:0] reg_idx
);
    // R10
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

    // R11
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R3
    we_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (int'(reg_idx) < NUM_REGS));

    // R11
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe && !reg_we));
endmodule

bind smb_blkreg_target smb_blkreg_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_s   (scl_s),
    .stop_det(stop_det),
    .sda_oe  (sda_oe),
    .reg_we  (reg_we),
    .reg_idx (reg_idx)
);

// File: tb/smb_blkreg_target_tb.sv
module smb_blkreg_target_tb;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] strap = 2'b01;
    logic       scl_h = 1'b1;
    logic       sda_h = 1'b1;
    logic       bus_sda;
    logic       sda_oe, reg_we;
    logic [7:0] reg_idx, reg_wdata, reg_rdata;
    logic [7:0] bank [16];
    int         wr_count = 0;
    int         oe_cycles = 0;
    int         errors = 0;
    int         checks = 0;

    always #10 clk = ~clk;

    assign bus_sda = sda_h & ~sda_oe;

    smb_blkreg_target u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap    (strap),
        .scl_i    (scl_h),
        .sda_i    (bus_sda),
        .sda_oe   (sda_oe),
        .reg_idx  (reg_idx),
        .reg_wdata(reg_wdata),
        .reg_we   (reg_we),
        .reg_rdata(reg_rdata)
    );

    always_comb reg_rdata = (reg_idx < 8'd16) ? bank[reg_idx[3:0]] : 8'h00;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) bank[i] <= 8'(8'h10 + i);
            bank[8] <= 8'h04;
        end else if (reg_we) begin
            bank[reg_idx[3:0]] <= reg_wdata;
            wr_count <= wr_count + 1;
        end
        if (sda_oe) oe_cycles <= oe_cycles + 1;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic h_start();
        sda_h = 1'b1; wq(); scl_h = 1'b1; wq(); sda_h = 1'b0; wq(); scl_h = 1'b0; wq();
    endtask

    task automatic h_stop();
        sda_h = 1'b0; wq(); scl_h = 1'b1; wq(); sda_h = 1'b1; wq();
    endtask

    task automatic h_bit(input logic b);
        sda_h = b; wq(); scl_h = 1'b1; wq(); wq(); scl_h = 1'b0; wq();
    endtask

    task automatic h_rbit(output logic b);
        sda_h = 1'b1; wq(); scl_h = 1'b1; wq(); b = bus_sda; wq(); scl_h = 1'b0; wq();
    endtask

    task automatic h_send(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) h_bit(v[i]);
        h_rbit(b);
        ack = ~b;
    endtask

    task automatic h_recv(input logic ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            h_rbit(b);
            v[i] = b;
        end
        h_bit(~ack);
    endtask

    task automatic t_reset();
        chk("R12", "sda_oe after reset", int'(sda_oe), 0);
        chk("R12", "reg_we after reset", int'(reg_we), 0);
    endtask

    task automatic t_write();
        logic a;
        int w0;
        w0 = wr_count;
        h_start();
        h_send(8'hD2, a); chk("R1", "addr ack", int'(a), 1);
        h_send(8'h02, a); chk("R2", "index ack", int'(a), 1);
        h_send(8'h03, a); chk("R2", "count ack", int'(a), 1);
        h_send(8'hA1, a); chk("R2", "data0 ack", int'(a), 1);
        h_send(8'hB2, a); chk("R2", "data1 ack", int'(a), 1);
        h_send(8'hC3, a); chk("R2", "data2 ack", int'(a), 1);
        h_stop();
        chk("R2", "bank2", int'(bank[2]), 'hA1);
        chk("R2", "bank3", int'(bank[3]), 'hB2);
        chk("R2", "bank4", int'(bank[4]), 'hC3);
        chk("R2", "write pulses", wr_count - w0, 3);
    endtask

    task automatic t_read();
        logic a;
        logic [7:0] v;
        h_start();
        h_send(8'hD2, a);
        h_send(8'h02, a);
        h_start();
        h_send(8'hD3, a); chk("R5", "read addr ack", int'(a), 1);
        h_recv(1'b1, v);  chk("R5", "count byte", int'(v), 'h04);
        h_recv(1'b1, v);  chk("R5", "reg2", int'(v), 'hA1);
        h_recv(1'b1, v);  chk("R5", "reg3", int'(v), 'hB2);
        h_recv(1'b0, v);  chk("R6", "reg4 last", int'(v), 'hC3);
        h_recv(1'b0, v);  chk("R6", "released after nack", int'(v), 'hFF);
        h_stop();
    endtask

    task automatic t_discard();
        logic a;
        int w0;
        w0 = wr_count;
        h_start();
        h_send(8'hD2, a);
        h_send(8'h0A, a);
        h_send(8'h04, a);
        h_send(8'h5E, a); chk("R3", "idx10 ack", int'(a), 1);
        h_send(8'h6F, a); chk("R3", "idx11 ack", int'(a), 1);
        h_send(8'h70, a); chk("R3", "idx12 ack", int'(a), 1);
        h_send(8'h81, a); chk("R3", "idx13 ack", int'(a), 1);
        h_stop();
        chk("R3", "bank11", int'(bank[11]), 'h6F);
        chk("R3", "bank12 kept", int'(bank[12]), 'h1C);
        chk("R3", "bank13 kept", int'(bank[13]), 'h1D);
        chk("R3", "write pulses", wr_count - w0, 2);
    endtask

    task automatic t_overcount();
        logic a;
        h_start();
        h_send(8'hD2, a);
        h_send(8'h00, a);
        h_send(8'h01, a);
        h_send(8'h33, a); chk("R4", "first data ack", int'(a), 1);
        h_send(8'h44, a); chk("R4", "extra data nack", int'(a), 0);
        h_send(8'h55, a); chk("R4", "ignored after nack", int'(a), 0);
        h_stop();
        chk("R4", "bank0", int'(bank[0]), 'h33);
        chk("R4", "bank1 kept", int'(bank[1]), 'h11);
    endtask

    task automatic t_badaddr();
        logic a;
        int w0, o0;
        w0 = wr_count;
        o0 = oe_cycles;
        h_start();
        h_send(8'hD4, a); chk("R7", "foreign addr nack", int'(a), 0);
        h_send(8'h01, a);
        h_send(8'h01, a);
        h_send(8'h05, a);
        h_stop();
        chk("R7", "no writes", wr_count - w0, 0);
        chk("R7", "never drove sda", oe_cycles - o0, 0);
    endtask

    task automatic t_plain_read();
        logic a;
        h_start();
        h_send(8'hD3, a); chk("R8", "read after plain start nack", int'(a), 0);
        h_stop();
    endtask

    task automatic t_strap_hold();
        logic a;
        strap = 2'b10;
        h_start();
        h_send(8'hD2, a); chk("R1", "strap change ignored", int'(a), 1);
        h_send(8'h05, a);
        h_send(8'h01, a);
        h_send(8'h5A, a);
        h_stop();
        chk("R1", "bank5", int'(bank[5]), 'h5A);
    endtask

    task automatic t_abort();
        logic a;
        h_start();
        h_bit(1'b1); h_bit(1'b1); h_bit(1'b0); h_bit(1'b1);
        h_stop();
        h_start();
        h_send(8'hD2, a); chk("R9", "ack after stop abort", int'(a), 1);
        h_send(8'h06, a);
        h_send(8'h01, a);
        h_send(8'h66, a);
        h_stop();
        chk("R9", "bank6", int'(bank[6]), 'h66);
        h_start();
        h_bit(1'b1); h_bit(1'b1); h_bit(1'b0);
        h_start();
        h_send(8'hD2, a); chk("R9", "ack after start abort", int'(a), 1);
        h_send(8'h07, a);
        h_send(8'h01, a);
        h_send(8'h77, a);
        h_stop();
        chk("R9", "bank7", int'(bank[7]), 'h77);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write();
        t_read();
        t_discard();
        t_overcount();
        t_badaddr();
        t_plain_read();
        t_strap_hold();
        t_abort();
        repeat (10) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule